// File: doc/BRIEF.md
# Chip-8 control-transfer execution unit

This unit carries out the four control-transfer operations of a Chip-8 core: unconditional jump (`1MMM`), subroutine call (`2MMM`), subroutine return (`00EE`), and jump to `MMM` plus V0 (`BMMM`). The surrounding core strobes `start_i` with a decoded opcode, the current program counter and the value of V0. The unit then runs for a fixed number of machine cycles and reports the new program counter in the cycle where `done_o` is high.

Return addresses live on an internal byte-wide stack that grows toward lower addresses. A call stores two bytes. The pointer steps down once and the low byte of the return address is written there. The pointer steps down again and the high byte is written at the new top, so the high byte ends at the lower address. A return reads the high byte first, then the low byte, and steps the pointer up after each read. Every operation has its own latency. For `BMMM` the latency is longer when the V0 addition carries into the next 256-byte page.

Top module: `c8_flow_unit`

## Requirements
- R1: Opcode `1MMM` (bits 15:12 = 0x1) gives `pc_o` = `MMM` with `pc_we_o` high in the done cycle. `busy_o` stays high for exactly 12 cycles, starting in the cycle after `start_i` is sampled.
- R2: Opcode `2MMM` (bits 15:12 = 0x2) pushes (`pc_i` + 2) mod 4096 onto the stack, lowers `sp_o` by 2 and gives `pc_o` = `MMM`. `busy_o` stays high for 26 cycles.
- R3: Opcode `0x00EE` raises `sp_o` by 2 and gives `pc_o` = the most recently pushed return address. `busy_o` stays high for 10 cycles.
- R4: Opcode `BMMM` (bits 15:12 = 0xB) with `MMM[7:0]` + V0 < 256 gives `pc_o` = `{MMM[11:8], MMM[7:0]+V0}`. `busy_o` stays high for 22 cycles.
- R5: Opcode `BMMM` with `MMM[7:0]` + V0 ≥ 256 adds 1 to the page nibble, wrapping within 12 bits (0xFFF-page carry lands on page 0). `busy_o` stays high for 24 cycles.
- R6: `done_o` and `pc_we_o` are high for exactly one cycle, which is the last busy cycle. `busy_o` is low in the cycle after it.
- R7: `start_i` is ignored while `busy_o` is high, including the done cycle. The running operation keeps its result and latency, and no second operation follows.
- R8: Any other opcode pulses `illegal_o` for one cycle in the cycle after the start. `busy_o` stays low, `pc_we_o` stays low and `sp_o` is unchanged.
- R9: After reset `sp_o` = 0xFF, and `busy_o`, `done_o`, `pc_we_o` and `illegal_o` are low.
- R10: The 8-bit stack pointer wraps silently in both directions. A return at 0xFF leaves 0x01, and a call at 0x01 leaves 0xFF.
- R11: Nested calls return in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| opcode_i | input | 16 | Decoded instruction word |
| pc_i | input | 12 | Program counter of the current instruction |
| v0_i | input | 8 | Current value of V0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last cycle of an operation |
| pc_we_o | output | 1 | `pc_o` is valid and must be loaded |
| pc_o | output | 12 | New program counter |
| illegal_o | output | 1 | One-cycle pulse for an unhandled opcode |
| sp_o | output | 8 | Current stack pointer |

## Verification
The end of one operation and the request for the next can fall in the same cycle: `done_o` is high and a new `start_i` arrives. The bench provokes this by raising `start_i` with a different opcode exactly in the cycle where it sees `done_o`. It also raises `start_i` once in the middle of a run. It judges the outcome on the ports. The running operation must keep its latency and target, `busy_o` must fall and stay low, and neither `sp_o` nor `pc_we_o` may show any trace of the second request.

// File: rtl/c8_flow_pkg.sv
package c8_flow_pkg;
  typedef enum logic [2:0] {
    OP_JMP  = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_JV0  = 3'd3,
    OP_ILL  = 3'd4
  } flow_op_e;
endpackage

// File: rtl/c8_flow_decode.sv
module c8_flow_decode
  import c8_flow_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 5,
  parameter int LAT_JMP  = 12,
  parameter int LAT_CALL = 26,
  parameter int LAT_RET  = 10,
  parameter int LAT_JV0  = 22,
  parameter int LAT_JV0C = 24
) (
  input  logic [15:0]       opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] v0_i,
  output flow_op_e          op_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic [CNT_W-1:0]  latency_o
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [DATA_W:0]   lo_sum;
  logic [PAGE_W-1:0] page;

  assign lo_sum     = {1'b0, opcode_i[DATA_W-1:0]} + {1'b0, v0_i};
  // page carry wraps inside the page field
  assign page       = opcode_i[ADDR_W-1:DATA_W] + PAGE_W'(lo_sum[DATA_W]);
  assign ret_addr_o = pc_i + ADDR_W'(2);

  always_comb begin
    op_o      = OP_ILL;
    target_o  = opcode_i[ADDR_W-1:0];
    latency_o = '0;
    unique case (opcode_i[15:12])
      4'h1: begin op_o = OP_JMP;  latency_o = CNT_W'(LAT_JMP);  end
      4'h2: begin op_o = OP_CALL; latency_o = CNT_W'(LAT_CALL); end
      4'hB: begin
        op_o      = OP_JV0;
        target_o  = {page, lo_sum[DATA_W-1:0]};
        latency_o = lo_sum[DATA_W] ? CNT_W'(LAT_JV0C) : CNT_W'(LAT_JV0);
      end
      4'h0: if (opcode_i == 16'h00EE) begin
        op_o = OP_RET; latency_o = CNT_W'(LAT_RET);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/c8_cycle_timer.sv
module c8_cycle_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             done_o
);
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        lim_q  <= limit_i;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o    = busy_q;
  assign elapsed_o = cnt_q;
  assign done_o    = busy_q && (cnt_q == lim_q - CNT_W'(1));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < lim_q);
endmodule

// File: rtl/c8_ret_stack.sv
module c8_ret_stack #(
  parameter int SP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_i,
  input  logic              inc_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SP_W-1:0]   sp_o
);
  localparam int DEPTH = 1 << SP_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [SP_W-1:0]   sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= '1;
    else if (dec_i) sp_q <= sp_q - SP_W'(1);
    else if (inc_i) sp_q <= sp_q + SP_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[sp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[sp_q];
  assign sp_o    = sp_q;

  // R10
  sp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) + SP_W'(1)) || (sp_q == $past(sp_q) - SP_W'(1)));

  // R2
  no_dec_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));
endmodule

// File: rtl/c8_flow_unit.sv
module c8_flow_unit
  import c8_flow_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int SP_W     = 8,
  parameter int LAT_JMP  = 12,
  parameter int LAT_CALL = 26,
  parameter int LAT_RET  = 10,
  parameter int LAT_JV0  = 22,
  parameter int LAT_JV0C = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] v0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              illegal_o,
  output logic [SP_W-1:0]   sp_o
);
  localparam int LAT_MAX = (LAT_CALL > LAT_JV0C) ? LAT_CALL : LAT_JV0C;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int PAGE_W  = ADDR_W - DATA_W;

  flow_op_e          dec_op, op_q;
  logic [ADDR_W-1:0] dec_tgt, dec_ret, tgt_q, ret_q;
  logic [CNT_W-1:0]  dec_lat, elapsed;
  logic              accept, busy, done, illegal_q;
  logic              st_dec, st_inc, st_we;
  logic [DATA_W-1:0] st_wdata, st_rdata, hi_q, lo_q;
  logic [15:0]       opc_q;

  c8_flow_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .LAT_JMP(LAT_JMP), .LAT_CALL(LAT_CALL), .LAT_RET(LAT_RET),
    .LAT_JV0(LAT_JV0), .LAT_JV0C(LAT_JV0C)
  ) u_decode (
    .opcode_i  (opcode_i),
    .pc_i      (pc_i),
    .v0_i      (v0_i),
    .op_o      (dec_op),
    .target_o  (dec_tgt),
    .ret_addr_o(dec_ret),
    .latency_o (dec_lat)
  );

  assign accept = start_i && !busy;

  c8_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept && dec_op != OP_ILL),
    .limit_i  (dec_lat),
    .busy_o   (busy),
    .elapsed_o(elapsed),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_ILL;
      tgt_q     <= '0;
      ret_q     <= '0;
      opc_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && dec_op == OP_ILL;
      if (accept && dec_op != OP_ILL) begin
        op_q  <= dec_op;
        tgt_q <= dec_tgt;
        ret_q <= dec_ret;
        opc_q <= opcode_i;
      end
    end
  end

  // stack micro-steps: call = dec, write lo + dec, write hi; return = read hi + inc, read lo + inc
  always_comb begin
    st_dec   = 1'b0;
    st_inc   = 1'b0;
    st_we    = 1'b0;
    st_wdata = '0;
    if (busy && op_q == OP_CALL) begin
      unique case (elapsed)
        CNT_W'(0): st_dec = 1'b1;
        CNT_W'(1): begin st_we = 1'b1; st_dec = 1'b1; st_wdata = ret_q[DATA_W-1:0]; end
        CNT_W'(2): begin st_we = 1'b1; st_wdata = DATA_W'(ret_q[ADDR_W-1:DATA_W]); end
        default: ;
      endcase
    end else if (busy && op_q == OP_RET) begin
      st_inc = (elapsed == CNT_W'(0)) || (elapsed == CNT_W'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (busy && op_q == OP_RET) begin
      if (elapsed == CNT_W'(0)) hi_q <= st_rdata;
      if (elapsed == CNT_W'(1)) lo_q <= st_rdata;
    end
  end

  c8_ret_stack #(.SP_W(SP_W), .DATA_W(DATA_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (st_dec),
    .inc_i  (st_inc),
    .we_i   (st_we),
    .wdata_i(st_wdata),
    .rdata_o(st_rdata),
    .sp_o   (sp_o)
  );

  assign busy_o    = busy;
  assign done_o    = done;
  assign pc_we_o   = done;
  assign illegal_o = illegal_q;
  assign pc_o      = !done             ? '0 :
                     (op_q == OP_RET)  ? {hi_q[PAGE_W-1:0], lo_q} : tgt_q;

  // R8
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !pc_we_o);

  // R1
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && opc_q[15:12] == 4'h1) |-> pc_o == opc_q[ADDR_W-1:0]);

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o && $stable(op_q));
endmodule

// File: tb/c8_flow_unit_bench.sv
`timescale 1ns/1ps
module c8_flow_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [11:0] pc = '0;
  logic [7:0]  v0 = '0;
  logic        busy, done, pc_we, illegal;
  logic [11:0] pc_out;
  logic [7:0]  sp;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  c8_flow_unit u_c8_flow_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pc_i(pc), .v0_i(v0), .busy_o(busy), .done_o(done), .pc_we_o(pc_we),
    .pc_o(pc_out), .illegal_o(illegal), .sp_o(sp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // inject: busy-cycle number at which a foreign start is raised (0 = none)
  task automatic run_op(input string req, input logic [15:0] op, input logic [11:0] cur_pc,
                        input logic [7:0] cur_v0, input int exp_lat, input bit chk_pc,
                        input logic [11:0] exp_pc, input logic [7:0] exp_sp, input int inject);
    int n = 0;
    int lat = 0;
    int dones = 0;
    logic [11:0] got_pc = '0;
    @(negedge clk);
    opcode = op; pc = cur_pc; v0 = cur_v0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (done) begin
        dones++; lat = n; got_pc = pc_out;
        chk(pc_we, {req, " pc_we in done cycle"}, pc_we, 1);
      end else begin
        chk(!pc_we, {req, " pc_we outside done"}, pc_we, 0);
      end
      if (n == inject) begin
        opcode = 16'h1777; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(dones == 1, {req, " R6 single done"}, dones, 1);
    if (chk_pc) chk(got_pc == exp_pc, {req, " target pc"}, got_pc, exp_pc);
    chk(sp == exp_sp, {req, " stack pointer"}, sp, exp_sp);
    @(negedge clk);
    chk(!busy && !done, {req, " idle after done"}, busy, 0);
  endtask

  task automatic test_illegal(input logic [15:0] op);
    logic [7:0] sp0 = sp;
    @(negedge clk);
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(illegal, "R8 illegal pulse", illegal, 1);
    chk(!busy && !pc_we, "R8 no busy/pc_we", busy, 0);
    @(negedge clk);
    chk(!illegal, "R8 illegal one cycle", illegal, 0);
    chk(!busy && !pc_we, "R8 still idle", busy, 0);
    chk(sp == sp0, "R8 sp unchanged", sp, sp0);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sp == 8'hFF, "R9 sp reset", sp, 8'hFF);
    chk(!busy && !done && !pc_we && !illegal, "R9 outputs idle", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R1 jump", 16'h1ABC, 12'h200, 8'h00, 12, 1, 12'hABC, 8'hFF, 0);
    run_op("R2 call", 16'h2345, 12'h200, 8'h00, 26, 1, 12'h345, 8'hFD, 0);
    run_op("R11 nested call", 16'h2678, 12'h346, 8'h00, 26, 1, 12'h678, 8'hFB, 0);
    run_op("R11 inner return", 16'h00EE, 12'h678, 8'h00, 10, 1, 12'h348, 8'hFD, 0);
    run_op("R3 outer return", 16'h00EE, 12'h348, 8'h00, 10, 1, 12'h202, 8'hFF, 0);
    run_op("R4 jv0 no carry", 16'hB123, 12'h000, 8'h10, 22, 1, 12'h133, 8'hFF, 0);
    run_op("R4 jv0 edge 0xFF", 16'hB0FF, 12'h000, 8'h00, 22, 1, 12'h0FF, 8'hFF, 0);
    run_op("R5 jv0 carry", 16'hB1F0, 12'h000, 8'h20, 24, 1, 12'h210, 8'hFF, 0);
    run_op("R5 jv0 wrap", 16'hBFFF, 12'h000, 8'h01, 24, 1, 12'h000, 8'hFF, 0);
    run_op("R2 call pc wrap", 16'h2400, 12'hFFE, 8'h00, 26, 1, 12'h400, 8'hFD, 0);
    run_op("R3 return wrap", 16'h00EE, 12'h400, 8'h00, 10, 1, 12'h000, 8'hFF, 0);
    run_op("R7 start mid-busy", 16'h1123, 12'h000, 8'h00, 12, 1, 12'h123, 8'hFF, 5);
    run_op("R7 start on done", 16'h1456, 12'h000, 8'h00, 12, 1, 12'h456, 8'hFF, 12);
    test_illegal(16'h00E0);
    test_illegal(16'h3000);
    run_op("R10 return underflow", 16'h00EE, 12'h000, 8'h00, 10, 0, 12'h000, 8'h01, 0);
    run_op("R10 call wrap", 16'h2050, 12'h010, 8'h00, 26, 1, 12'h050, 8'hFF, 0);
    run_op("R10 return after wrap", 16'h00EE, 12'h050, 8'h00, 10, 1, 12'h012, 8'h01, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule